// File: doc/BRIEF.md
# Modem Line Control and Change Detector

This block handles the modem handshake lines of a serial port. Two outputs are driven from a control register: a terminal-ready line and a request-to-send line. Each pin carries the inverse of the bit software writes. A third control bit drives a loopback enable that goes to the serial core. Four inputs are also monitored: clear-to-send, carrier-detect, ring and data-set-ready. Each input passes through a two-flop synchroniser, and its level can be read from a status register.

Clear-to-send and carrier-detect each feed a change detector. By default only a falling edge of the synchronised line counts as a change. A per-line any-edge option makes rising edges count as well. A detected change latches a flag only when that line's mask bit is set. Reading the status register clears the latched flags. One pending output, the OR of the masked flags, goes to the port's main interrupt logic.

Top module: `modem_line_ctl`

## Requirements
- R1: After reset, control and configuration bits and both change flags are zero, so the terminal-ready and request-to-send pins are high, the loopback enable is low and the pending output is low.
- R2: A write to address 0 stores wdata[2:0]. The terminal-ready pin shows the inverse of bit 0 and the request-to-send pin shows the inverse of bit 1 from the following cycle. Bit 2 drives the loopback enable. A read of address 0 returns these three bits and zeros above them.
- R3: A read of address 1 returns the synchronised input levels in bits 0 (clear-to-send), 1 (carrier-detect), 2 (ring) and 3 (data-set-ready). A pin change becomes visible two clock edges after it is applied.
- R4: When a line's any-edge bit is clear, a falling edge of that line latches its flag and a rising edge does not.
- R5: When a line's any-edge bit is set, both rising and falling edges latch the flag.
- R6: A change on a line whose mask bit is clear latches no flag.
- R7: A read of address 1 returns the flags in bit 4 (clear-to-send) and bit 5 (carrier-detect), then clears them. A change detected in the same cycle as the read survives the clear.
- R8: The pending output is high exactly when some latched flag has its mask bit set. Clearing a mask bit therefore lowers the pending output without clearing the flag.
- R9: A write to address 1 stores wdata[11:8] as the configuration: bit 8 is the clear-to-send mask, bit 9 the carrier-detect mask, bit 10 the clear-to-send any-edge bit and bit 11 the carrier-detect any-edge bit. These bits read back in the same positions. Ring and data-set-ready never latch a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 1 clears the flags) |
| addr | input | 1 | Register select: 0 control, 1 status/configuration |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from addr |
| cts_i | input | 1 | Clear-to-send input |
| dcd_i | input | 1 | Carrier-detect input |
| ri_i | input | 1 | Ring input |
| dsr_i | input | 1 | Data-set-ready input |
| dtr_o | output | 1 | Terminal-ready pin, inverse of control bit 0 |
| rts_o | output | 1 | Request-to-send pin, inverse of control bit 1 |
| loop_en_o | output | 1 | Loopback enable |
| chg_pend_o | output | 1 | Masked change pending |

## Verification
The bench drives a rising edge on clear-to-send with any-edge clear. A detector that fires on either edge would latch a flag there. It applies a carrier-detect change timed so that detection lands in the same cycle as a status read. A design that gives the clear priority over the set would lose that event, and the next read would show no flag. It clears a mask while a flag is latched. A design that gates the flag itself, instead of the pending output, would hide the stored flag on the next read. It also toggles ring and data-set-ready with every option enabled, and checks pin polarity after reset and after writes, which catches a missing inversion.

// File: rtl/modem_line_ctl.sv
module modem_line_ctl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cts_i,
  input  logic          dcd_i,
  input  logic          ri_i,
  input  logic          dsr_i,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          loop_en_o,
  output logic          chg_pend_o
);
  localparam int NLINE = 4;
  localparam int NCHG  = 2;

  logic [NLINE-1:0] s1_q, s2_q;
  logic [NCHG-1:0]  prev_q, flag_q, mask_q, any_q, hit, set;
  logic [2:0]       ctrl_q;
  logic             st_rd;

  assign st_rd = rd_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= {dsr_i, ri_i, dcd_i, cts_i};
      s2_q   <= s1_q;
      prev_q <= s2_q[NCHG-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NCHG; i++) begin
      hit[i] = any_q[i] ? (s2_q[i] ^ prev_q[i]) : (prev_q[i] & ~s2_q[i]);
      set[i] = hit[i] & mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      any_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && !addr) ctrl_q <= wdata[2:0];
      if (wr_en && addr) begin
        mask_q <= wdata[9:8];
        any_q  <= wdata[11:10];
      end
      flag_q <= (st_rd ? '0 : flag_q) | set;
    end
  end

  assign dtr_o      = ~ctrl_q[0];
  assign rts_o      = ~ctrl_q[1];
  assign loop_en_o  = ctrl_q[2];
  assign chg_pend_o = |(flag_q & mask_q);

  always_comb begin
    rdata = '0;
    if (!addr) rdata[2:0] = ctrl_q;
    else begin
      rdata[3:0]   = s2_q;
      rdata[5:4]   = flag_q;
      rdata[9:8]   = mask_q;
      rdata[11:10] = any_q;
    end
  end

  a_r2_pin_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> (dtr_o == !$past(wdata[0]) && rts_o == !$past(wdata[1])));
  a_r4_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_q[0] && !prev_q[0] && s2_q[0] && !flag_q[0]) |=> !flag_q[0]);
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00 && flag_q == 2'b00) |=> flag_q == 2'b00);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && set == 2'b00) |=> flag_q == 2'b00);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && set[1]) |=> flag_q[1]);
  a_r8_pending: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pend_o |-> (flag_q != 2'b00));
endmodule

// File: tb/modem_line_ctl_tb.sv
module modem_line_ctl_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, addr = 0;
  logic [15:0] wdata = '0, rdata;
  logic cts = 1, dcd = 1, ri = 1, dsr = 1;
  logic dtr, rts, lpb, pend;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [3:0] cfg = 0;

  always #2 clk = ~clk;

  modem_line_ctl #(.DW(16)) dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cts_i(cts), .dcd_i(dcd), .ri_i(ri),
    .dsr_i(dsr), .dtr_o(dtr), .rts_o(rts), .loop_en_o(lpb), .chg_pend_o(pend));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rd_en) begin
    if (exp_q.size() == 0) check("scoreboard underflow", rdata, 16'hxxxx);
    else check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  function automatic logic [15:0] st(logic fc, logic fd);
    return {4'h0, cfg, 2'b00, fd, fc, dsr, ri, dcd, cts};
  endfunction

  task automatic wr(logic a, logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic a, logic [15:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic setcfg(logic [3:0] c);
    cfg = c; wr(1, {4'h0, c, 8'h00});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 dtr pin", dtr, 1); check("R1 rts pin", rts, 1);
    check("R1 loopback", lpb, 0); check("R1 pending", pend, 0);
    settle();
    rd(0, 16'h0000, "R1 control reset");
    rd(1, st(0, 0), "R3 levels idle R1 flags");

    wr(0, 16'h0005);
    check("R2 dtr inverted", dtr, 0); check("R2 rts inverted", rts, 1); check("R2 loop", lpb, 1);
    rd(0, 16'h0005, "R2 readback");
    wr(0, 16'hFFFA);
    check("R2 dtr second", dtr, 1); check("R2 rts second", rts, 0); check("R2 loop second", lpb, 0);

    setcfg(4'hF);
    rd(1, st(0, 0), "R9 config readback");
    ri = 0; dsr = 0; settle();
    ri = 1; settle();
    rd(1, st(0, 0), "R9 ring/dsr no flag");
    check("R9 pending", pend, 0);

    setcfg(4'h0);
    cts = 0; settle();
    rd(1, st(0, 0), "R6 masked cts fall");
    check("R6 pending", pend, 0);

    setcfg(4'h1);
    cts = 1; settle();
    rd(1, st(0, 0), "R4 rising ignored");
    cts = 0; settle();
    check("R8 pending set", pend, 1);
    rd(1, st(1, 0), "R4 falling latched R7 shows flag");
    rd(1, st(0, 0), "R7 cleared by read");
    check("R8 pending after clear", pend, 0);

    setcfg(4'hA);
    dcd = 0; settle();
    rd(1, st(0, 1), "R5 dcd fall");
    dcd = 1; settle();
    rd(1, st(0, 1), "R5 dcd rise");
    rd(1, st(0, 0), "R7 dcd cleared");

    dcd = 0; settle();
    setcfg(4'h8);
    check("R8 pending drops with mask", pend, 0);
    rd(1, st(0, 1), "R8 flag kept while masked");

    setcfg(4'hA);
    dcd = 1;
    @(posedge clk); @(posedge clk); #1;
    rd(1, st(0, 0), "R7 collision read");
    rd(1, st(0, 1), "R7 set survives clear");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule